// File: doc/BRIEF.md
# Comparator channel control word with enable lock

This block holds the configuration of two comparator channels behind a simple register bus, one 32-bit word per channel. Each word carries a filter length, hysteresis, output routing, input swap, two input selectors, an interrupt condition, a speed setting, a single-shot flag and an enable bit. The configuration fields feed the comparator side directly and are not synchronized. The enable bit crosses into the comparator clock through a toggle handshake.

While a channel's enable reads one, or while an enable change is still in flight, the channel's configuration fields are frozen and writes to them are refused. Software starts a channel by writing its word with bit 0 set. The enable read-back keeps showing the old value until the comparator domain has applied the change and acknowledged it. Only after a disable has been acknowledged can the fields be rewritten.

Top module: `cmpctl_top`

## Requirements
- R1: After reset both channel words read 0x00000000, `cmp_en_o` is 0 and `cmp_cfg_o` is all zeros.
- R2: Channel n (n = 0, 1) is reached only at byte address 0x10 + 4*n. Every other address reads zero, and a write to it changes no channel word.
- R3: Only the bits in mask 0x070BB76E plus bit 0 are stored. These are filter 26:24, hysteresis 19, output 17:16, swap 15, positive select 13:12, negative select 10:8, interrupt 6:5, speed 3:2, single 1 and enable 0. All other bits read zero. `cmp_cfg_o[32*n+31:32*n]` shows channel n's stored fields at the same positions, with bit 0 at zero.
- R4: While a channel is unlocked, a write stores its configuration fields, and they are readable from the next bus cycle.
- R5: While a channel's enable reads one, a write leaves its configuration fields unchanged.
- R6: A change of enable reaches `cmp_en_o[n]` no fewer than 2 and no more than 4 comparator-clock edges after the bus write.
- R7: The enable bit reads its old value right after the write. It reads the new value only once `cmp_en_o[n]` already holds that value.
- R8: After a disable is written, the configuration fields stay locked until the enable read-back shows zero.
- R9: In a write that changes enable and the fields together, the fields are updated only if the channel was unlocked before that write. Enabling a channel therefore stores the fields, and disabling it does not.
- R10: A write whose bit 0 equals the current read-back, or that arrives while a change is in flight, does not start a new enable change.
- R11: The two channels are independent. Writes to one channel never alter the other channel's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| cclk | input | 1 | Comparator clock |
| crst | input | 1 | Synchronous active-high reset, comparator domain |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe, one write per bus cycle |
| rdata | output | 32 | Combinational read data for `addr` |
| cmp_en_o | output | 2 | Synchronized enable per channel, comparator domain |
| cmp_cfg_o | output | 64 | Configuration words per channel, unsynchronized |

## Verification
Read data and configuration outputs follow a write at the next bus edge. The bench therefore samples them half a bus cycle after the write edge. The enable takes two synchronizer stages plus one update edge in the comparator clock, about 3 edges. The bench timestamps every change of `cmp_en_o` against a free-running comparator-edge count and accepts 2 to 4 edges. The read-back needs two more bus-clock synchronizer stages after the acknowledge. The bench polls it, and on the first read that shows the new value it checks that the comparator side already shows it too. Lock checks are made both inside the in-flight window and after it.

// File: rtl/cmpctl_pkg.sv
package cmpctl_pkg;

    localparam int WORD_W = 32;

    // stored configuration bits, enable (bit 0) excluded
    localparam logic [WORD_W-1:0] FIELD_MASK = 32'h070B_B76E;

    typedef struct packed {
        logic [4:0] rsv_hi;
        logic [2:0] filt_len;
        logic [3:0] rsv_20;
        logic       hyst_on;
        logic       rsv_18;
        logic [1:0] out_route;
        logic       swap_in;
        logic       rsv_14;
        logic [1:0] pos_sel;
        logic       rsv_11;
        logic [2:0] neg_sel;
        logic       rsv_7;
        logic [1:0] irq_cond;
        logic       rsv_4;
        logic [1:0] speed;
        logic       one_shot;
        logic       enable;
    } cmp_word_t;

    function automatic cmp_word_t scrub_fields(input logic [WORD_W-1:0] w);
        return cmp_word_t'(w & FIELD_MASK);
    endfunction

endpackage

// File: rtl/cmpctl_sync.sv
module cmpctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cmpctl_chan.sv
module cmpctl_chan
    import cmpctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cclk,
    input  logic              crst,
    input  logic              wr_hit,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_word,
    output logic              cmp_en,
    output logic [WORD_W-1:0] cmp_cfg
);
    cmp_word_t cfg_q;
    logic      en_rd;      // enable as seen by the bus
    logic      en_tgt;     // enable value being transferred
    logic      busy;
    logic      req_tgl;
    logic      ack_seen;
    logic      ack_bus;
    logic      req_cmp;
    logic      ack_tgl;
    logic      lock;
    logic      start;

    assign lock  = en_rd | busy;
    assign start = wr_hit && !busy && (wdata[0] != en_rd);

    // bus domain
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            en_rd    <= 1'b0;
            en_tgt   <= 1'b0;
            busy     <= 1'b0;
            req_tgl  <= 1'b0;
            ack_seen <= 1'b0;
        end else begin
            if (wr_hit && !lock)
                cfg_q <= scrub_fields(wdata);
            if (start) begin
                en_tgt  <= wdata[0];
                req_tgl <= ~req_tgl;
                busy    <= 1'b1;
            end else if (busy && (ack_bus != ack_seen)) begin
                busy     <= 1'b0;
                en_rd    <= en_tgt;
                ack_seen <= ack_bus;
            end
        end
    end

    cmpctl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(cclk), .rst(crst), .d(req_tgl), .q(req_cmp)
    );

    // comparator domain: en_tgt is held steady while busy
    always_ff @(posedge cclk) begin
        if (crst) begin
            cmp_en  <= 1'b0;
            ack_tgl <= 1'b0;
        end else if (req_cmp != ack_tgl) begin
            cmp_en  <= en_tgt;
            ack_tgl <= ~ack_tgl;
        end
    end

    cmpctl_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk), .rst(rst), .d(ack_tgl), .q(ack_bus)
    );

    always_comb begin
        cmp_word_t w;
        w        = cfg_q;
        w.enable = en_rd;
        rd_word  = w;
    end

    assign cmp_cfg = cfg_q;

    AST_CFG_FROZEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(cfg_q)); // R5
    AST_RDBACK_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        !$stable(en_rd) |-> $fell(busy)); // R7
    AST_TARGET_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(en_tgt)); // R10
    AST_ACK_CARRIES_CHANGE: assert property (@(posedge cclk) disable iff (crst)
        !$stable(ack_tgl) |-> !$stable(cmp_en)); // R6
endmodule

// File: rtl/cmpctl_top.sv
module cmpctl_top
    import cmpctl_pkg::*;
#(
    parameter int              NCH         = 2,
    parameter int              ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] BASE      = 8'h10,
    parameter int              SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cclk,
    input  logic                  crst,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [WORD_W-1:0]     wdata,
    input  logic                  we,
    output logic [WORD_W-1:0]     rdata,
    output logic [NCH-1:0]        cmp_en_o,
    output logic [NCH*WORD_W-1:0] cmp_cfg_o
);
    localparam int STRIDE = WORD_W / 8;

    logic [NCH-1:0]             hit;
    logic [NCH-1:0][WORD_W-1:0] rd_w;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign hit[n] = (addr == BASE + ADDR_W'(STRIDE * n));

        cmpctl_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .cclk   (cclk),
            .crst   (crst),
            .wr_hit (we && hit[n]),
            .wdata  (wdata),
            .rd_word(rd_w[n]),
            .cmp_en (cmp_en_o[n]),
            .cmp_cfg(cmp_cfg_o[n*WORD_W +: WORD_W])
        );
    end

    always_comb begin
        rdata = '0;
        for (int n = 0; n < NCH; n++)
            if (hit[n]) rdata = rdata | rd_w[n];
    end

    AST_RSV_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rdata & ~(FIELD_MASK | 32'h1)) == '0); // R3
    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (hit == '0) |-> (rdata == '0)); // R2
endmodule

// File: tb/test_cmpctl_top.sv
`timescale 1ns/100ps
module test_cmpctl_top;
    localparam logic [31:0] MASK = 32'h070B_B76E;

    logic        clk = 0, cclk = 0, rst = 1, crst = 1;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic        we = 0;
    logic [31:0] rdata;
    logic [1:0]  cmp_en_o;
    logic [63:0] cmp_cfg_o;

    int checks = 0, failures = 0;
    int ccnt = 0, wr_cc = 0;
    int chg_cc [2];
    logic [1:0] en_prev = 0;
    int  bus_cyc = 0;
    bit  done = 0;

    always #4 clk = ~clk;     // 125 MHz
    always #5.5 cclk = ~cclk;

    cmpctl_top i_cmpctl_top (
        .clk(clk), .rst(rst), .cclk(cclk), .crst(crst),
        .addr(addr), .wdata(wdata), .we(we), .rdata(rdata),
        .cmp_en_o(cmp_en_o), .cmp_cfg_o(cmp_cfg_o)
    );

    always @(posedge cclk) ccnt <= ccnt + 1;
    always @(negedge cclk) begin
        for (int n = 0; n < 2; n++)
            if (cmp_en_o[n] !== en_prev[n]) chg_cc[n] = ccnt;
        en_prev = cmp_en_o;
    end

    always @(posedge clk) begin
        bus_cyc <= bus_cyc + 1;
        if (bus_cyc > 150000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", bus_cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1;
        @(posedge clk);
        #1;
        we = 0;
        wr_cc = ccnt;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic [7:0] ch_addr(input int n);
        return 8'h10 + 8'(4 * n);
    endfunction

    // poll read-back enable until it equals v; check ordering against comparator side
    task automatic wait_en(input int n, input logic v, input string req);
        logic [31:0] d;
        bit seen = 0;
        for (int k = 0; k < 60 && !seen; k++) begin
            rd(ch_addr(n), d);
            if (d[0] == v) begin
                seen = 1;
                chk(cmp_en_o[n] == v, "R7", 32'(cmp_en_o[n]), 32'(v));
            end
        end
        chk(seen, req, d, {d[31:1], v});
    endtask

    initial begin
        logic [31:0] d, pat, exp0, exp1, p2;
        int lat;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0; crst = 0;

        // R1 reset state
        rd(ch_addr(0), d); chk(d == 0, "R1", d, 0);
        rd(ch_addr(1), d); chk(d == 0, "R1", d, 0);
        chk(cmp_en_o == 0, "R1", 32'(cmp_en_o), 0);
        chk(cmp_cfg_o == 0, "R1", cmp_cfg_o[31:0] | cmp_cfg_o[63:32], 0);

        // R3 R4 R11 sweep of field patterns while disabled
        exp0 = 0; exp1 = 0;
        for (int i = 0; i < 48; i++) begin
            for (int n = 0; n < 2; n++) begin
                pat = (i == 0) ? 32'hFFFF_FFFE : ((32'(i) * 32'h9E37_79B9) ^ (32'(i) << 7));
                pat[0] = 1'b0;
                wr(ch_addr(n), pat);
                if (n == 0) exp0 = pat & MASK; else exp1 = pat & MASK;
                rd(ch_addr(n), d);
                chk(d == (pat & MASK), "R4", d, pat & MASK);
                chk(cmp_cfg_o[n*32 +: 32] == (pat & MASK), "R3", cmp_cfg_o[n*32 +: 32], pat & MASK);
                rd(ch_addr(1 - n), d);
                chk(d == ((n == 0) ? exp1 : exp0), "R11", d, (n == 0) ? exp1 : exp0);
            end
        end

        // R2 every other address: reads zero, writes ignored
        for (int a = 0; a < 64; a++) begin
            if (a == 8'h10 || a == 8'h14) continue;
            wr(8'(a), 32'hFFFF_FFFF);
            rd(8'(a), d); chk(d == 0, "R2", d, 0);
        end
        rd(ch_addr(0), d); chk(d == exp0, "R2", d, exp0);
        rd(ch_addr(1), d); chk(d == exp1, "R2", d, exp1);
        chk(cmp_en_o == 0, "R2", 32'(cmp_en_o), 0);

        // R9 enable together with new fields while unlocked
        pat = 32'h0501_A345;                     // enable bit set
        wr(ch_addr(0), pat);
        rd(ch_addr(0), d);
        chk(d == (pat & MASK), "R9", d, pat & MASK);   // fields stored, enable still old
        chk(d[0] == 0, "R7", 32'(d[0]), 0);
        // R10 disable request while in flight is ignored; R8 lock while busy
        wr(ch_addr(0), 32'h0000_0000);
        rd(ch_addr(0), d);
        chk((d & MASK) == (pat & MASK), "R8", d & MASK, pat & MASK);
        wait_en(0, 1'b1, "R7");
        lat = chg_cc[0] - wr_cc;
        exp0 = pat & MASK;
        repeat (8) @(posedge clk);
        chk(cmp_en_o[0] == 1, "R10", 32'(cmp_en_o[0]), 1);
        rd(ch_addr(0), d); chk(d == (exp0 | 1), "R10", d, exp0 | 1);

        // R6 latency of a lone enable on channel 1
        wr(ch_addr(1), exp1 | 32'h1);
        wait_en(1, 1'b1, "R7");
        lat = chg_cc[1] - wr_cc;
        chk(lat >= 2 && lat <= 4, "R6", 32'(lat), 3);
        exp1 = exp1 & MASK;

        // R5 writes refused while enabled; R10 rewriting enable=1 starts nothing
        wr(ch_addr(0), 32'h0203_4561);
        rd(ch_addr(0), d); chk(d == (exp0 | 1), "R5", d, exp0 | 1);
        chk(cmp_cfg_o[31:0] == exp0, "R5", cmp_cfg_o[31:0], exp0);
        rd(ch_addr(0), d); chk(d[0] == 1, "R10", 32'(d[0]), 1);

        // R9 disable with fields: fields not taken; R8 locked in flight
        p2 = 32'h0000_1224;
        wr(ch_addr(0), p2);
        rd(ch_addr(0), d);
        chk(d == (exp0 | 1), "R9", d, exp0 | 1);
        wr(ch_addr(0), 32'h0608_0862);
        rd(ch_addr(0), d);
        chk((d & MASK) == exp0, "R8", d & MASK, exp0);
        wait_en(0, 1'b0, "R8");
        chk(cmp_en_o[0] == 0, "R6", 32'(cmp_en_o[0]), 0);
        rd(ch_addr(1), d); chk(d == (exp1 | 1), "R11", d, exp1 | 1);

        // R6 disable latency on channel 1
        wr(ch_addr(1), 32'h0);
        wait_en(1, 1'b0, "R7");
        lat = chg_cc[1] - wr_cc;
        chk(lat >= 2 && lat <= 4, "R6", 32'(lat), 3);

        // R4 unlocked again after the disable completed
        wr(ch_addr(0), p2);
        rd(ch_addr(0), d); chk(d == (p2 & MASK), "R4", d, p2 & MASK);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule